// File: doc/BRIEF.md
# Serial DAC Command Shifter

This block loads a four-channel, 8-bit serial DAC over three wires: a serial clock, a serial data line and an active-low load strobe. A requester presents a 2-bit channel number, a gain flag and an 8-bit code, then pulses `start` for one cycle. The block builds an 11-bit word from these fields and shifts it out most significant bit first. Each bit is placed on the data line as the serial clock rises, and the DAC takes it on the falling edge. When all bits have been sent, the block pulses the load line so the DAC updates its output.

The serial clock comes from a free-running divider. The divider gives a one-cycle enable tick every `2**DIV_W` system clocks, and each serial half-period lasts one tick interval. The controller has three states. In ST_IDLE the block waits for `start`: a start pulse moves it to ST_SEND. In ST_SEND it shifts the bits, and when the last bit has been clocked out it moves to ST_STORE. In ST_STORE it drives the load line low for one tick interval, then returns to ST_IDLE. `busy` is high in every state except ST_IDLE. `done` pulses once, in the cycle the block returns to ST_IDLE.

Top module: `dac_cmd_shifter`

## Requirements
- R1: When `rst` is high, the next clock edge sets `sclk` to 0, `load_n` to 1, `sdata` to 0, and `busy` and `done` to 0.
- R2: One accepted start sends exactly 11 bits, taken on the falling edges of `sclk`, in this order: `chan[1]`, `chan[0]`, `gain_x2`, then `code[7]` down to `code[0]`. `gain_x2`=1 selects twice the reference and 0 selects once the reference.
- R3: `sdata` changes only in the cycle in which `sclk` rises, so the data line is stable while `sclk` is high and across its falling edge.
- R4: Every high phase of `sclk` lasts exactly `2**DIV_W` system clocks.
- R5: After the 11th falling edge, `load_n` goes low for exactly `2**DIV_W` system clocks, and `sclk` stays low while `load_n` is low.
- R6: `done` is high for exactly one cycle per frame. That cycle is the one in which `load_n` returns high, and `busy` is low in it.
- R7: `busy` is high from the cycle after an accepted start until `done`. While `busy` is low, `sclk` is low and `load_n` is high.
- R8: A `start` pulse given while `busy` is high is ignored. The frame in progress is unchanged, no extra `done` follows, and `busy` stays low once the frame ends.
- R9: A `start` pulse given in the same cycle as `done` is accepted and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a word |
| chan | input | 2 | DAC channel number |
| gain_x2 | input | 1 | Gain flag: 1 for twice the reference, 0 for once |
| code | input | 8 | Output code for the DAC |
| sclk | output | 1 | Serial clock, low when idle |
| sdata | output | 1 | Serial data, MSB first |
| load_n | output | 1 | Active-low load strobe, high when idle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Two events can fall in the same cycle: the `done` pulse that ends one frame and a new request from the requester. The bench provokes this by raising `start` in the very cycle it sees `done`. It judges the result by decoding the next frame from the falling edges of `sclk` and comparing it with a word the bench builds itself. The bench also places stray start pulses at random cycles inside frames. A stray pulse passes only if the decoded frame is unchanged and exactly one `done` is seen.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_STORE = 2'd2
    } dac_state_e;
endpackage

// File: rtl/dac_tick_div.sv
// Free-running divider: one-cycle tick every 2**DIV_W clocks.
module dac_tick_div #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= (cnt_q == {DIV_W{1'b1}});
        end
    end
endmodule

// File: rtl/dac_bit_counter.sv
// Counts shifted bits; flags the final bit of the frame.
module dac_bit_counter #(
    parameter int CNT_W   = 5,
    parameter int FRAME_W = 11
) (
    input  logic clk,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/dac_cmd_shifter.sv
module dac_cmd_shifter
    import dac_cmd_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEL_W-1:0]  chan,
    input  logic              gain_x2,
    input  logic [DATA_W-1:0] code,
    output logic              sclk,
    output logic              sdata,
    output logic              load_n,
    output logic              busy,
    output logic              done
);
    localparam int FRAME_W = SEL_W + 1 + DATA_W;

    dac_state_e state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic tick, frame_last, cnt_clr, cnt_inc;

    dac_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign cnt_clr = rst || (state_q == ST_IDLE);
    assign cnt_inc = (state_q == ST_SEND) && tick && sclk;

    dac_bit_counter #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_bits (
        .clk  (clk),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .last (frame_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SEND;
            ST_SEND:  if (tick && sclk && frame_last) state_d = ST_STORE;
            ST_STORE: if (tick && !load_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk    <= 1'b0;
            sdata   <= 1'b0;
            load_n  <= 1'b1;
            done    <= 1'b0;
            shreg_q <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) shreg_q <= {chan, gain_x2, code};
                end
                ST_SEND: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk  <= 1'b1;
                            sdata <= shreg_q[FRAME_W-1];
                        end else begin
                            sclk    <= 1'b0;
                            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                ST_STORE: begin
                    if (tick) begin
                        if (load_n) begin
                            load_n <= 1'b0;
                        end else begin
                            load_n <= 1'b1;
                            done   <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/dac_cmd_shifter_chk.sv
module dac_cmd_shifter_chk (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic sdata,
    input logic load_n,
    input logic busy,
    input logic done
);
    AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdata) |-> $rose(sclk)); // R3
    AST_NO_CLK_IN_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> !sclk); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6
    AST_DONE_AT_LOAD_END: assert property (@(posedge clk) disable iff (rst)
        $rose(load_n) |-> (done && !busy)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (load_n && !sclk)); // R7
endmodule

bind dac_cmd_shifter dac_cmd_shifter_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .sclk   (sclk),
    .sdata  (sdata),
    .load_n (load_n),
    .busy   (busy),
    .done   (done)
);

// File: tb/dac_cmd_shifter_tb.sv
module dac_cmd_shifter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 2;
    localparam int DIV_N      = 1 << DIV_W;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0] chan = '0;
    logic gain_x2 = 1'b0;
    logic [7:0] code = '0;
    logic sclk, sdata, load_n, busy, done;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_shifter #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .chan(chan), .gain_x2(gain_x2),
        .code(code), .sclk(sclk), .sdata(sdata), .load_n(load_n),
        .busy(busy), .done(done)
    );

    function automatic logic [10:0] expect_word(logic [1:0] c, logic g, logic [7:0] d);
        return {c, g, d};
    endfunction

    task automatic check(string req, logic ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller is at a negedge. Drives start now, returns at the negedge where done is seen.
    task automatic run_frame(logic [1:0] c, logic g, logic [7:0] d, int stray_at);
        logic [10:0] got = '0;
        int nbits = 0, hi_cnt = 0, lo_cnt = 0, cyc = 0, dones = 0;
        logic hi_ok = 1'b1, busy_ok = 1'b1, prev_sclk = 1'b0, prev_load = 1'b1;
        chan = c; gain_x2 = g; code = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 busy after start", busy == 1'b1, busy, 1);
        check("R9 done cleared", done == 1'b0, done, 0);
        prev_sclk = sclk;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (stray_at > 0 && cyc == stray_at) begin
                start = 1'b1; chan = ~c; gain_x2 = ~g; code = ~d;
            end
            if (sclk) hi_cnt++;
            if (prev_sclk && !sclk) begin
                got = {got[9:0], sdata};
                nbits++;
                if (hi_cnt != DIV_N) hi_ok = 1'b0;
                hi_cnt = 0;
            end
            if (!load_n) lo_cnt++;
            if (done) dones++;
            else if (!busy) busy_ok = 1'b0;
            prev_sclk = sclk;
            prev_load = load_n;
        end
        start = 1'b0;
        check("R2 frame word", got == expect_word(c, g, d), got, expect_word(c, g, d));
        check("R2 bit count", nbits == 11, nbits, 11);
        check("R4 sclk high time", hi_ok, hi_ok, 1);
        check("R5 load low length", lo_cnt == DIV_N, lo_cnt, DIV_N);
        check("R6 done with load high and idle", done && load_n && !busy, {done, load_n, busy}, 3'b110);
        check("R7 busy held during frame", busy_ok, busy_ok, 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset sclk", sclk == 1'b0, sclk, 0);
        check("R1 reset load_n", load_n == 1'b1, load_n, 1);
        check("R1 reset sdata", sdata == 1'b0, sdata, 0);
        check("R1 reset busy/done", !busy && !done, {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corner words
        run_frame(2'b11, 1'b1, 8'hFF, 0);
        repeat (2) @(negedge clk);
        run_frame(2'b00, 1'b0, 8'h00, 0);
        repeat (5) @(negedge clk);
        run_frame(2'b10, 1'b0, 8'h81, 0);
        // R9: start in the done cycle
        run_frame(2'b01, 1'b1, 8'h5A, 0);
        // R8: stray start mid-frame, then confirm nothing follows
        run_frame(2'b10, 1'b1, 8'h3C, 17);
        begin
            int extra = 0;
            repeat (60) begin
                @(negedge clk);
                if (busy || done) extra++;
            end
            check("R8 stray start ignored", extra == 0, extra, 0);
        end

        // Constrained random frames
        for (int i = 0; i < 40; i++) begin
            logic [1:0] rc = 2'($urandom);
            logic rg = 1'($urandom);
            logic [7:0] rd = 8'($urandom);
            int gap = $urandom % 4;
            int stray = ($urandom % 3 == 0) ? 1 + ($urandom % 90) : 0;
            repeat (gap) @(negedge clk);
            run_frame(rc, rg, rd, stray);
        end

        // Reset during a frame
        @(negedge clk);
        start = 1'b1; chan = 2'b01; code = 8'hA5;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-frame", !sclk && load_n && !busy && !done, {sclk, load_n, busy, done}, 4'b0100);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule